// File: doc/BRIEF.md
# Synthesiser Loop Digital Core

This block holds the digital part of a frequency synthesiser loop. It runs on one system clock. Two single-cycle strobes arrive on that clock. One marks each edge of the RF signal after a fixed divide-by-8 prescaler. The other marks each edge of the reference clock. The RF strobes drive a divider with a programmable 15-bit ratio. The reference strobes drive a fixed divider, 512 by default, so a 4 MHz reference gives a 7.8125 kHz comparison rate. The synthesised frequency is therefore ratio × 8 × the comparison rate.

A phase-frequency comparator takes the two divided pulses. It emits "raise" and "lower" requests for an external charge pump. A lock detector watches how long those requests stay active in each comparison period and raises a lock flag. Four control inputs do the following:
- select the pump current;
- switch the pump off;
- switch the varactor drive off;
- enable a test routing that places the two comparator inputs on two general-purpose port outputs instead of their programmed levels.

The prescaler and the analog pump are outside this block.

Top module: `synth_loop_core`

## Requirements
- R1: The feedback path emits one pulse per `ratio_i` RF strobes. After reset the first RF strobe produces a pulse. With the test routing on, N strobes give floor((N-1)/ratio)+1 pulses on `port_b_o`.
- R2: The reference path emits one pulse per REF_DIV (512) reference strobes. The first strobe after reset pulses. With the test routing on, these pulses appear on `port_a_o`.
- R3: When the reference pulse leads the feedback pulse by d cycles, `pump_up_o` is high for exactly d cycles and `pump_dn_o` stays low.
- R4: When the feedback pulse leads by d cycles, `pump_dn_o` is high for exactly d cycles and `pump_up_o` stays low.
- R5: Coincident reference and feedback pulses produce no pump request.
- R6: With `pump_off_i` = 1, `pump_up_o`, `pump_dn_o` and `pump_en_o` are all 0 one cycle later. With `pump_off_i` = 0, `pump_en_o` is 1.
- R7: `cur_hi_o` follows `cur_sel_i` (1 = high current) and `drv_off_o` follows `drv_off_i`, each one cycle later.
- R8: With `test_route_i` = 0, `port_a_o` and `port_b_o` follow `port_a_i` and `port_b_i` one cycle later. With `test_route_i` = 1 they carry the reference and feedback pulses and ignore the port inputs.
- R9: `lock_o` rises once LOCK_CNT (4) consecutive comparison periods each have a summed request width of at most THRESH (4) cycles. A constant offset above THRESH never locks.
- R10: `lock_o` falls at the first comparison period whose request width exceeds THRESH.
- R11: A new `ratio_i` takes effect only at the feedback divider's terminal count, so the period already running completes at the old length.
- R12: Ratios 0 and 1 both divide by one.
- R13: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_tick_i | input | 1 | One strobe per prescaled RF edge |
| ref_tick_i | input | 1 | One strobe per reference edge |
| ratio_i | input | 15 | Feedback division ratio |
| cur_sel_i | input | 1 | 1 selects high pump current |
| pump_off_i | input | 1 | 1 disables the charge pump |
| test_route_i | input | 1 | 1 routes comparator inputs to the port outputs |
| drv_off_i | input | 1 | 1 switches the varactor drive off |
| port_a_i | input | 1 | Programmed level for port A |
| port_b_i | input | 1 | Programmed level for port B |
| pump_up_o | output | 1 | Raise-frequency request |
| pump_dn_o | output | 1 | Lower-frequency request |
| pump_en_o | output | 1 | Pump output enable |
| cur_hi_o | output | 1 | High-current select |
| drv_off_o | output | 1 | Varactor drive disable |
| port_a_o | output | 1 | Port A: level or reference pulse |
| port_b_o | output | 1 | Port B: level or feedback pulse |
| lock_o | output | 1 | Lock flag |

## Verification
Control bits and port levels reach the outputs one cycle after they are driven. A divider pulse reaches a port output two cycles after its terminal strobe. A pump request reaches the output three cycles after that strobe. A lock decision reaches `lock_o` three cycles after the reference terminal strobe that closes a period. The bench checks controls one cycle after it drives them. It measures divider periods as intervals between port pulses, so the fixed latency cancels out. It counts pump cycles and divider pulses over windows followed by idle cycles, so every pair in flight has settled before the count is compared. It samples the lock flag tens of cycles away from each decision point.

// File: rtl/synth_pkg.sv
package synth_pkg;
  typedef struct packed {
    logic cur_hi;
    logic pump_off;
    logic test_route;
    logic drv_off;
  } ctrl_t;
endpackage

// File: rtl/fb_divider.sv
module fb_divider #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic [W-1:0] ratio_i,
  output logic         pulse_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] reload;

  // ratio 0 behaves as ratio 1
  always_comb reload = (ratio_i == '0) ? '0 : ratio_i - W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i) begin
        if (cnt == '0) begin
          pulse_o <= 1'b1;
          cnt     <= reload;   // new ratio sampled only here (R11)
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end

  a_r1_pulse_at_terminal: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt == '0) |=> pulse_o);
  a_r1_quiet_without_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> !pulse_o);
endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int DIV = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int RW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [RW-1:0] LAST = RW'(DIV - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick_i) begin
        if (cnt == '0) begin
          pulse_o <= 1'b1;
          cnt     <= LAST;
        end else begin
          cnt <= cnt - RW'(1);
        end
      end
    end
  end

  a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  a_r2_pulse_needs_tick: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(tick_i));
endmodule

// File: rtl/phase_cmp.sv
module phase_cmp (
  input  logic clk,
  input  logic rst,
  input  logic ref_p_i,
  input  logic div_p_i,
  output logic up_o,
  output logic dn_o
);
  logic set_up;
  logic set_dn;

  always_comb begin
    set_up = up_o | ref_p_i;
    set_dn = dn_o | div_p_i;
  end

  // both set -> both cleared
  always_ff @(posedge clk) begin
    if (rst) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= set_up & ~set_dn;
      dn_o <= set_dn & ~set_up;
    end
  end

  a_r3_ref_raises_up: assert property (@(posedge clk) disable iff (rst)
    (ref_p_i && !div_p_i && !dn_o) |=> up_o);
  a_r4_div_raises_dn: assert property (@(posedge clk) disable iff (rst)
    (div_p_i && !ref_p_i && !up_o) |=> dn_o);
  a_r5_never_both: assert property (@(posedge clk) disable iff (rst)
    !(up_o && dn_o));
endmodule

// File: rtl/lock_det.sv
module lock_det #(
  parameter int WW       = 8,
  parameter int THRESH   = 4,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic eval_i,
  input  logic act_i,
  output logic lock_o
);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam logic [WW-1:0] LIM  = WW'(THRESH);
  localparam logic [GW-1:0] GMAX = GW'(LOCK_CNT);
  localparam logic [GW-1:0] GPRE = GW'(LOCK_CNT - 1);

  logic [WW-1:0] wcnt;
  logic [WW-1:0] wsum;
  logic [GW-1:0] good;

  always_comb begin
    wsum = wcnt;
    if (act_i && wcnt != {WW{1'b1}}) wsum = wcnt + WW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      good   <= '0;
      lock_o <= 1'b0;
    end else if (eval_i) begin
      wcnt <= '0;
      if (wsum <= LIM) begin
        if (good != GMAX) good <= good + GW'(1);
        if (good >= GPRE) lock_o <= 1'b1;
      end else begin
        good   <= '0;
        lock_o <= 1'b0;
      end
    end else begin
      wcnt <= wsum;
    end
  end

  a_r9_rise_on_eval: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(eval_i));
  a_r9_rise_needs_history: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> ($past(good) >= GPRE));
  a_r10_drop_on_wide: assert property (@(posedge clk) disable iff (rst)
    (eval_i && wsum > LIM) |=> !lock_o);
endmodule

// File: rtl/synth_loop_core.sv
module synth_loop_core
  import synth_pkg::*;
#(
  parameter int DIV_W    = 15,
  parameter int REF_DIV  = 512,
  parameter int WIN_W    = 8,
  parameter int THRESH   = 4,
  parameter int LOCK_CNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rf_tick_i,
  input  logic             ref_tick_i,
  input  logic [DIV_W-1:0] ratio_i,
  input  logic             cur_sel_i,
  input  logic             pump_off_i,
  input  logic             test_route_i,
  input  logic             drv_off_i,
  input  logic             port_a_i,
  input  logic             port_b_i,
  output logic             pump_up_o,
  output logic             pump_dn_o,
  output logic             pump_en_o,
  output logic             cur_hi_o,
  output logic             drv_off_o,
  output logic             port_a_o,
  output logic             port_b_o,
  output logic             lock_o
);
  ctrl_t ctl;
  logic  ref_p;
  logic  div_p;
  logic  up;
  logic  dn;
  logic  locked;

  always_comb begin
    ctl.cur_hi     = cur_sel_i;
    ctl.pump_off   = pump_off_i;
    ctl.test_route = test_route_i;
    ctl.drv_off    = drv_off_i;
  end

  fb_divider #(.W(DIV_W)) fb_i (
    .clk(clk), .rst(rst), .tick_i(rf_tick_i), .ratio_i(ratio_i), .pulse_o(div_p)
  );

  ref_divider #(.DIV(REF_DIV)) rd_i (
    .clk(clk), .rst(rst), .tick_i(ref_tick_i), .pulse_o(ref_p)
  );

  phase_cmp pc_i (
    .clk(clk), .rst(rst), .ref_p_i(ref_p), .div_p_i(div_p), .up_o(up), .dn_o(dn)
  );

  lock_det #(.WW(WIN_W), .THRESH(THRESH), .LOCK_CNT(LOCK_CNT)) ld_i (
    .clk(clk), .rst(rst), .eval_i(ref_p), .act_i(up | dn), .lock_o(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up_o <= 1'b0;
      pump_dn_o <= 1'b0;
      pump_en_o <= 1'b0;
      cur_hi_o  <= 1'b0;
      drv_off_o <= 1'b0;
      port_a_o  <= 1'b0;
      port_b_o  <= 1'b0;
      lock_o    <= 1'b0;
    end else begin
      pump_up_o <= up & ~ctl.pump_off;
      pump_dn_o <= dn & ~ctl.pump_off;
      pump_en_o <= ~ctl.pump_off;
      cur_hi_o  <= ctl.cur_hi;
      drv_off_o <= ctl.drv_off;
      port_a_o  <= ctl.test_route ? ref_p : port_a_i;
      port_b_o  <= ctl.test_route ? div_p : port_b_i;
      lock_o    <= locked;
    end
  end

  a_r6_pump_off: assert property (@(posedge clk) disable iff (rst)
    pump_off_i |=> (!pump_up_o && !pump_dn_o && !pump_en_o));
  a_r8_route_ref: assert property (@(posedge clk) disable iff (rst)
    test_route_i |=> (port_a_o == $past(ref_p)));
  a_r8_route_div: assert property (@(posedge clk) disable iff (rst)
    test_route_i |=> (port_b_o == $past(div_p)));
  a_r5_outputs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pump_up_o && pump_dn_o));
endmodule

// File: tb/synth_loop_core_tb_top.sv
module synth_loop_core_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        rf_tick_i = 1'b0, ref_tick_i = 1'b0;
  logic [14:0] ratio_i = 15'd512;
  logic        cur_sel_i = 1'b0, pump_off_i = 1'b0, test_route_i = 1'b0, drv_off_i = 1'b0;
  logic        port_a_i = 1'b0, port_b_i = 1'b0;
  logic        pump_up_o, pump_dn_o, pump_en_o, cur_hi_o, drv_off_o, port_a_o, port_b_o, lock_o;

  int total = 0;
  int bad   = 0;

  synth_loop_core dut_i (
    .clk(clk), .rst(rst), .rf_tick_i(rf_tick_i), .ref_tick_i(ref_tick_i), .ratio_i(ratio_i),
    .cur_sel_i(cur_sel_i), .pump_off_i(pump_off_i), .test_route_i(test_route_i),
    .drv_off_i(drv_off_i), .port_a_i(port_a_i), .port_b_i(port_b_i),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_en_o(pump_en_o),
    .cur_hi_o(cur_hi_o), .drv_off_o(drv_off_o), .port_a_o(port_a_o),
    .port_b_o(port_b_o), .lock_o(lock_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int n, input int r);
    int rr = (r < 1) ? 1 : r;
    return (n - 1) / rr + 1;
  endfunction

  task automatic do_reset();
    rst = 1'b1; rf_tick_i = 1'b0; ref_tick_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // cycles between consecutive pulses on port_b_o
  task automatic b_interval(output int n);
    do @(negedge clk); while (!port_b_o);
    n = 0;
    do begin @(negedge clk); n++; end while (!port_b_o);
  endtask

  task automatic run_offset(input int a, input int b, input logic off,
                            output int ups, output int dns, output int ens);
    ratio_i = 15'd512; test_route_i = 1'b0; pump_off_i = off;
    do_reset();
    ups = 0; dns = 0; ens = 0;
    for (int i = 0; i < 1100; i++) begin
      @(negedge clk);
      ups += int'(pump_up_o); dns += int'(pump_dn_o); ens += int'(pump_en_o);
      ref_tick_i = (i >= a); rf_tick_i = (i >= b);
    end
    ref_tick_i = 1'b0; rf_tick_i = 1'b0;
    repeat (10) begin
      @(negedge clk);
      ups += int'(pump_up_o); dns += int'(pump_dn_o); ens += int'(pump_en_o);
    end
    pump_off_i = 1'b0;
  endtask

  task automatic run_lock(input int b, input bit pause,
                          output int l0, output int l1, output int l2, output int l3);
    ratio_i = 15'd512; test_route_i = 1'b0; pump_off_i = 1'b0;
    do_reset();
    for (int i = 0; i < 3200; i++) begin
      @(negedge clk);
      if (i == 1526) l0 = int'(lock_o);
      if (i == 1556) l1 = int'(lock_o);
      if (i == 3000) l2 = int'(lock_o);
      if (i == 3100) l3 = int'(lock_o);
      ref_tick_i = 1'b1;
      rf_tick_i  = (i >= b) && !(pause && i >= 2148 && i < 2158);
    end
    ref_tick_i = 1'b0; rf_tick_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int u, d, e, n, r, cnt, l0, l1, l2, l3;
    void'($urandom(32'd4711));

    // R13 reset state
    cur_sel_i = 1'b1; drv_off_i = 1'b1; port_a_i = 1'b1; port_b_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R13 outputs in reset",
        int'({pump_up_o, pump_dn_o, pump_en_o, cur_hi_o, drv_off_o, port_a_o, port_b_o, lock_o}), 0);
    cur_sel_i = 1'b0; drv_off_i = 1'b0; port_a_i = 1'b0; port_b_i = 1'b0;
    do_reset();

    // R7 control follow
    @(negedge clk); cur_sel_i = 1'b1; drv_off_i = 1'b1;
    @(negedge clk); chk("R7 cur_hi set", int'(cur_hi_o), 1); chk("R7 drv_off set", int'(drv_off_o), 1);
    chk("R6 pump enabled", int'(pump_en_o), 1);
    cur_sel_i = 1'b0;
    @(negedge clk); chk("R7 cur_hi clear", int'(cur_hi_o), 0); chk("R7 drv_off held", int'(drv_off_o), 1);
    drv_off_i = 1'b0;

    // R8 normal port levels, then override
    port_a_i = 1'b1; port_b_i = 1'b0;
    @(negedge clk); chk("R8 port_a level", int'(port_a_o), 1); chk("R8 port_b level", int'(port_b_o), 0);
    port_a_i = 1'b0; port_b_i = 1'b1;
    @(negedge clk); chk("R8 port_a level2", int'(port_a_o), 0); chk("R8 port_b level2", int'(port_b_o), 1);
    port_a_i = 1'b1; test_route_i = 1'b1;
    @(negedge clk); chk("R8 override a", int'(port_a_o), 0); chk("R8 override b", int'(port_b_o), 0);
    port_a_i = 1'b0; port_b_i = 1'b0;

    // R1 random ratios, constant strobes
    for (int k = 0; k < 5; k++) begin
      r = 2 + int'($urandom % 60);
      ratio_i = 15'(r); test_route_i = 1'b1;
      do_reset(); rf_tick_i = 1'b1;
      b_interval(n); chk("R1 interval", n, r);
      b_interval(n); chk("R1 interval again", n, r);
    end
    rf_tick_i = 1'b0;

    // R1 random strobe gaps
    for (int k = 0; k < 3; k++) begin
      r = 3 + int'($urandom % 18);
      n = 60 + int'($urandom % 140);
      ratio_i = 15'(r); do_reset();
      cnt = 0;
      for (int t = 0; t < n; ) begin
        @(negedge clk); cnt += int'(port_b_o);
        rf_tick_i = $urandom % 2 == 0;
        if (rf_tick_i) t++;
      end
      @(negedge clk); cnt += int'(port_b_o); rf_tick_i = 1'b0;
      repeat (5) begin @(negedge clk); cnt += int'(port_b_o); end
      chk("R1 pulse count", cnt, exp_pulses(n, r));
    end

    // R12 ratios 0 and 1
    ratio_i = 15'd0; do_reset(); rf_tick_i = 1'b1;
    b_interval(n); chk("R12 ratio 0", n, 1);
    ratio_i = 15'd1; b_interval(n); b_interval(n); chk("R12 ratio 1", n, 1);
    rf_tick_i = 1'b0;

    // R11 ratio change mid-period
    ratio_i = 15'd10; do_reset(); rf_tick_i = 1'b1;
    b_interval(n); chk("R11 first", n, 10);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 3) ratio_i = 15'd25;
    end while (!port_b_o);
    chk("R11 running period kept", n, 10);
    b_interval(n); chk("R11 new ratio", n, 25);
    rf_tick_i = 1'b0;

    // R2 reference interval and count
    do_reset(); ref_tick_i = 1'b1;
    n = 0;
    do @(negedge clk); while (!port_a_o);
    do begin @(negedge clk); n++; end while (!port_a_o);
    chk("R2 interval", n, 512);
    n = 1030 + int'($urandom % 470);
    do_reset(); cnt = 0;
    for (int t = 0; t < n; ) begin
      @(negedge clk); cnt += int'(port_a_o);
      ref_tick_i = $urandom % 4 != 0;
      if (ref_tick_i) t++;
    end
    @(negedge clk); cnt += int'(port_a_o); ref_tick_i = 1'b0;
    repeat (5) begin @(negedge clk); cnt += int'(port_a_o); end
    chk("R2 pulse count", cnt, exp_pulses(n, 512));
    test_route_i = 1'b0;

    // R3 / R4 / R5 / R6 phase comparison
    run_offset(0, 3, 1'b0, u, d, e);
    chk("R3 up width", u, 9); chk("R3 no dn", d, 0);
    r = 1 + int'($urandom % 20);
    run_offset(0, r, 1'b0, u, d, e);
    chk("R3 up width random", u, 3 * r);
    run_offset(5, 0, 1'b0, u, d, e);
    chk("R4 dn width", d, 15); chk("R4 no up", u, 0);
    run_offset(2, 2, 1'b0, u, d, e);
    chk("R5 coincident", u + d, 0);
    run_offset(0, 6, 1'b1, u, d, e);
    chk("R6 pump off up/dn", u + d, 0); chk("R6 pump off enable", e, 0);

    // R9 / R10 lock
    run_lock(0, 1'b1, l0, l1, l2, l3);
    chk("R9 not yet locked", l0, 0); chk("R9 locked", l1, 1);
    chk("R10 still locked", l2, 1); chk("R10 dropped", l3, 0);
    run_lock(3, 1'b0, l0, l1, l2, l3);
    chk("R9 small offset locks", l1, 1);
    run_lock(8, 1'b0, l0, l1, l2, l3);
    chk("R9 wide offset no lock", l1, 0); chk("R9 wide offset stays", l3, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule